// File: doc/BRIEF.md
# Three-Level Descriptor Table Walker

The walker turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A request latches the virtual address and the two words of a root pointer. The root pointer uses the same layout as a long table descriptor. The walk then visits up to three table levels:

- Level A holds 8-byte long descriptors.
- Levels B and C hold 4-byte short descriptors.

A two-bit type field in each descriptor decides what happens next. The walk either moves on to the next table, finishes on a page mapping at that level, or stops with a fault code. Long descriptors also carry a limit that bounds the index into the next table. The write-protect bits of every descriptor visited are ORed into the result.

The controller is a single state machine with these states:

- `ST_IDLE` waits for `xl_req`, then moves to `ST_ROOT`.
- `ST_ROOT` decodes the latched root pointer with no memory access. It goes to `ST_DONE` on an invalid type, a page type or a limit violation, and to `ST_A_ATTR` otherwise.
- `ST_A_ATTR` reads the attribute word of the level A entry. It goes to `ST_DONE` on an invalid type or a limit violation, and to `ST_A_ADDR` otherwise.
- `ST_A_ADDR` reads the address word of the same entry. It goes to `ST_DONE` on a page, and to `ST_B` on a table.
- `ST_B` reads the level B entry. It goes to `ST_DONE` on an invalid type or a page, and to `ST_C` on a table.
- `ST_C` reads the level C entry and always goes to `ST_DONE`.
- `ST_DONE` raises `xl_done` for one cycle and returns to `ST_IDLE`.

Each read state holds its request until `mem_ack` arrives.

Top module: `va_table_walker`

## Requirements
- R1: After reset, `xl_done`, `mem_req`, `xl_wp`, `xl_fault` and `xl_pa` are all zero.
- R2: The virtual address is split into fields: index A is bits 31:25, index B is bits 24:19, index C is bits 18:13, and the page offset is bits 12:0. On success, `xl_pa` is bits 31:13 of the page base word joined with the offset bits 12:0.
- R3: The type field is bits 1:0 of a descriptor: 00 invalid, 01 page, 10 or 11 next table. The level A entry is two words at base+8·A. The attribute word is read first, then the address word at +4. Level B and C entries are at base+4·index. Table bases come from the root base word, the level A address word and the level B word, each with bits 3:0 cleared.
- R4: A page type ends the walk successfully at the level where it is found: the root, A, B or C. The page base is taken from, respectively, the root base word, the level A address word, the level B word or the level C word.
- R5: An invalid type ends the walk with fault code 1 at the root, 2 at level A, 3 at level B and 4 at level C.
- R6: For a table-type root, the limit is checked against index A. The limit flag is bit 31 and the limit is bits 30:16. With flag 0 the index must be at most the limit; with flag 1 it must be at least the limit. A violation gives fault 5, and no memory read is made.
- R7: A table-type level A attribute word applies the same limit rule to index B. A violation gives fault 6, and the address word of that entry is not read.
- R8: A table type found in a level C entry gives fault 7.
- R9: `xl_wp` is the OR of bit 2 of every descriptor word that carries attributes and was visited. These are the root attribute word, the level A attribute word, and the B and C words.
- R10: `xl_done` is high for exactly one cycle per walk. After it, `xl_pa`, `xl_wp` and `xl_fault` hold until the next accepted request. On a fault, `xl_pa` is zero.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req` and `mem_addr` stay unchanged. Every read address is word aligned.
- R12: `xl_req` and `xl_va` are ignored while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_attr | input | 32 | Root pointer attribute word: limit flag, limit, write-protect bit, type |
| root_base | input | 32 | Root pointer base word: physical base of the level A table |
| xl_req | input | 1 | Start a translation, sampled only when idle |
| xl_va | input | 32 | Virtual address to translate |
| xl_done | output | 1 | One-cycle pulse when the walk ends |
| xl_pa | output | 32 | Translated physical address, zero on fault |
| xl_wp | output | 1 | Accumulated write-protect status |
| xl_fault | output | 3 | 0 ok, 1–4 invalid at root/A/B/C, 5 root limit, 6 level A limit, 7 table at level C |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Word address of the read |
| mem_ack | input | 1 | Read acknowledge, one cycle, with data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The hardest situations to reach are the early exits: a page mapping at the root or at level A, and the two limit faults. Each of these must end the walk without the reads that would otherwise follow. The bench therefore builds a memory image with long page entries, entries with both limit polarities and deliberately invalid slots. It then counts and logs each read, so that a skipped or extra fetch shows up as a wrong read count or address. A slow acknowledge and a second request fired mid-walk cover the request hold and the busy-time ignore rule.

// File: rtl/vtw_pkg.sv
package vtw_pkg;

    typedef enum logic [1:0] {
        DT_NONE  = 2'b00,
        DT_PAGE  = 2'b01,
        DT_SHORT = 2'b10,
        DT_LONG  = 2'b11
    } desc_type_e;

    typedef enum logic [2:0] {
        FLT_OK       = 3'd0,
        FLT_ROOT_INV = 3'd1,
        FLT_A_INV    = 3'd2,
        FLT_B_INV    = 3'd3,
        FLT_C_INV    = 3'd4,
        FLT_ROOT_LIM = 3'd5,
        FLT_A_LIM    = 3'd6,
        FLT_C_TBL    = 3'd7
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROOT,
        ST_A_ATTR,
        ST_A_ADDR,
        ST_B,
        ST_C,
        ST_DONE
    } walk_state_e;

    localparam int WP_BIT    = 2;
    localparam int BASE_LSB  = 4;
    localparam int LIM_LSB   = 16;
    localparam int LIM_W     = 15;
    localparam int LFLAG_BIT = 31;

endpackage

// File: rtl/vtw_va_split.sv
module vtw_va_split #(
    parameter int VA_W    = 32,
    parameter int A_IDX_W = 7,
    parameter int B_IDX_W = 6,
    parameter int C_IDX_W = 6,
    localparam int OFS_W  = VA_W - A_IDX_W - B_IDX_W - C_IDX_W
) (
    input  logic [VA_W-1:0]    va,
    output logic [A_IDX_W-1:0] a_idx,
    output logic [B_IDX_W-1:0] b_idx,
    output logic [C_IDX_W-1:0] c_idx,
    output logic [OFS_W-1:0]   ofs
);
    assign {a_idx, b_idx, c_idx, ofs} = va;
endmodule

// File: rtl/vtw_limit_chk.sv
module vtw_limit_chk #(
    parameter int IDX_W = 7,
    parameter int LIM_W = 15
) (
    input  logic             lim_flag,
    input  logic [LIM_W-1:0] lim_val,
    input  logic [IDX_W-1:0] idx,
    output logic             in_range
);
    logic [LIM_W-1:0] idx_ext;
    assign idx_ext = LIM_W'(idx);

    always_comb begin
        if (lim_flag) begin
            in_range = (idx_ext >= lim_val);
        end else begin
            in_range = (idx_ext <= lim_val);
        end
    end
endmodule

// File: rtl/vtw_entry_addr.sv
module vtw_entry_addr #(
    parameter int AW     = 32,
    parameter int IDX_W  = 7,
    parameter int SHIFT  = 3,
    parameter int LSB    = 4
) (
    input  logic [AW-1:LSB]  base_hi,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] base_full;
    assign base_full = {base_hi, {LSB{1'b0}}};
    assign addr      = base_full + (AW'(idx) << SHIFT);
endmodule

// File: rtl/va_table_walker.sv
module va_table_walker
    import vtw_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int A_IDX_W = 7,
    parameter int B_IDX_W = 6,
    parameter int C_IDX_W = 6,
    localparam int OFS_W  = VA_W - A_IDX_W - B_IDX_W - C_IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     root_attr,
    input  logic [VA_W-1:0] root_base,
    input  logic            xl_req,
    input  logic [VA_W-1:0] xl_va,
    output logic            xl_done,
    output logic [VA_W-1:0] xl_pa,
    output logic            xl_wp,
    output logic [2:0]      xl_fault,
    output logic            mem_req,
    output logic [VA_W-1:0] mem_addr,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata
);

    walk_state_e     state_q, state_d;
    logic [VA_W-1:0] va_q;
    logic [31:0]     attr_q;
    logic [VA_W-1:0] base_q;
    logic [VA_W-1:0] pa_q;
    logic            wp_q;
    fault_e          fault_q;

    logic [A_IDX_W-1:0] a_idx;
    logic [B_IDX_W-1:0] b_idx;
    logic [C_IDX_W-1:0] c_idx;
    logic [OFS_W-1:0]   ofs;

    vtw_va_split #(
        .VA_W(VA_W), .A_IDX_W(A_IDX_W), .B_IDX_W(B_IDX_W), .C_IDX_W(C_IDX_W)
    ) u_split (
        .va(va_q), .a_idx(a_idx), .b_idx(b_idx), .c_idx(c_idx), .ofs(ofs)
    );

    // limit checks: root limit bounds index A, level A limit bounds index B
    logic root_lim_ok, a_lim_ok;

    vtw_limit_chk #(.IDX_W(A_IDX_W), .LIM_W(LIM_W)) u_lim_root (
        .lim_flag(attr_q[LFLAG_BIT]),
        .lim_val (attr_q[LIM_LSB +: LIM_W]),
        .idx     (a_idx),
        .in_range(root_lim_ok)
    );

    vtw_limit_chk #(.IDX_W(B_IDX_W), .LIM_W(LIM_W)) u_lim_a (
        .lim_flag(mem_rdata[LFLAG_BIT]),
        .lim_val (mem_rdata[LIM_LSB +: LIM_W]),
        .idx     (b_idx),
        .in_range(a_lim_ok)
    );

    // entry addresses for the three levels
    logic [VA_W-1:0] a_entry, b_entry, c_entry;

    vtw_entry_addr #(.AW(VA_W), .IDX_W(A_IDX_W), .SHIFT(3), .LSB(BASE_LSB)) u_ea_a (
        .base_hi(base_q[VA_W-1:BASE_LSB]), .idx(a_idx), .addr(a_entry)
    );
    vtw_entry_addr #(.AW(VA_W), .IDX_W(B_IDX_W), .SHIFT(2), .LSB(BASE_LSB)) u_ea_b (
        .base_hi(base_q[VA_W-1:BASE_LSB]), .idx(b_idx), .addr(b_entry)
    );
    vtw_entry_addr #(.AW(VA_W), .IDX_W(C_IDX_W), .SHIFT(2), .LSB(BASE_LSB)) u_ea_c (
        .base_hi(base_q[VA_W-1:BASE_LSB]), .idx(c_idx), .addr(c_entry)
    );

    // decoded types
    desc_type_e root_type, rd_type, a_held_type;
    assign root_type   = desc_type_e'(attr_q[1:0]);
    assign rd_type     = desc_type_e'(mem_rdata[1:0]);
    assign a_held_type = desc_type_e'(attr_q[1:0]);

    logic root_is_tbl, rd_is_tbl;
    assign root_is_tbl = (root_type == DT_SHORT) || (root_type == DT_LONG);
    assign rd_is_tbl   = (rd_type == DT_SHORT) || (rd_type == DT_LONG);

    logic sink_unused;
    assign sink_unused = ^{attr_q[LIM_LSB-1:WP_BIT+1], base_q[BASE_LSB-1:0]};

    // memory port
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        unique case (state_q)
            ST_A_ATTR: begin mem_req = 1'b1; mem_addr = a_entry; end
            ST_A_ADDR: begin mem_req = 1'b1; mem_addr = a_entry + VA_W'(4); end
            ST_B:      begin mem_req = 1'b1; mem_addr = b_entry; end
            ST_C:      begin mem_req = 1'b1; mem_addr = c_entry; end
            default:   ;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (xl_req) state_d = ST_ROOT;
            ST_ROOT: begin
                if (root_is_tbl && root_lim_ok) state_d = ST_A_ATTR;
                else                            state_d = ST_DONE;
            end
            ST_A_ATTR: if (mem_ack) begin
                if (rd_type == DT_NONE)           state_d = ST_DONE;
                else if (rd_is_tbl && !a_lim_ok)  state_d = ST_DONE;
                else                              state_d = ST_A_ADDR;
            end
            ST_A_ADDR: if (mem_ack) begin
                if (a_held_type == DT_PAGE) state_d = ST_DONE;
                else                        state_d = ST_B;
            end
            ST_B: if (mem_ack) begin
                if (rd_is_tbl) state_d = ST_C;
                else           state_d = ST_DONE;
            end
            ST_C:    if (mem_ack) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            attr_q  <= '0;
            base_q  <= '0;
            pa_q    <= '0;
            wp_q    <= 1'b0;
            fault_q <= FLT_OK;
        end else begin
            unique case (state_q)
                ST_IDLE: if (xl_req) begin
                    va_q    <= xl_va;
                    attr_q  <= root_attr;
                    base_q  <= root_base;
                    pa_q    <= '0;
                    wp_q    <= 1'b0;
                    fault_q <= FLT_OK;
                end
                ST_ROOT: begin
                    wp_q <= attr_q[WP_BIT];
                    if (root_type == DT_NONE)  fault_q <= FLT_ROOT_INV;
                    else if (root_type == DT_PAGE)
                        pa_q <= {base_q[VA_W-1:OFS_W], ofs};
                    else if (!root_lim_ok)     fault_q <= FLT_ROOT_LIM;
                end
                ST_A_ATTR: if (mem_ack) begin
                    attr_q <= mem_rdata;
                    wp_q   <= wp_q | mem_rdata[WP_BIT];
                    if (rd_type == DT_NONE)          fault_q <= FLT_A_INV;
                    else if (rd_is_tbl && !a_lim_ok) fault_q <= FLT_A_LIM;
                end
                ST_A_ADDR: if (mem_ack) begin
                    if (a_held_type == DT_PAGE) pa_q   <= {mem_rdata[VA_W-1:OFS_W], ofs};
                    else                        base_q <= mem_rdata;
                end
                ST_B: if (mem_ack) begin
                    wp_q <= wp_q | mem_rdata[WP_BIT];
                    if (rd_type == DT_NONE)      fault_q <= FLT_B_INV;
                    else if (rd_type == DT_PAGE) pa_q    <= {mem_rdata[VA_W-1:OFS_W], ofs};
                    else                         base_q  <= mem_rdata;
                end
                ST_C: if (mem_ack) begin
                    wp_q <= wp_q | mem_rdata[WP_BIT];
                    if (rd_type == DT_NONE)      fault_q <= FLT_C_INV;
                    else if (rd_type == DT_PAGE) pa_q    <= {mem_rdata[VA_W-1:OFS_W], ofs};
                    else                         fault_q <= FLT_C_TBL;
                end
                default: ;
            endcase
        end
    end

    assign xl_done  = (state_q == ST_DONE);
    assign xl_pa    = pa_q;
    assign xl_wp    = wp_q;
    assign xl_fault = fault_q;

endmodule

// File: rtl/vtw_checker.sv
module vtw_checker #(
    parameter int VA_W  = 32,
    parameter int OFS_W = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic            mem_ack,
    input logic [VA_W-1:0] mem_addr,
    input logic            xl_done,
    input logic [VA_W-1:0] xl_pa,
    input logic [2:0]      xl_fault,
    input logic [OFS_W-1:0] va_ofs
);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_word_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |=> !xl_done);

    assert_fault_zero_pa_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && xl_fault != 3'd0) |-> (xl_pa == '0));

    assert_no_read_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |-> !mem_req);

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && xl_fault == 3'd0) |-> (xl_pa[OFS_W-1:0] == va_ofs));

endmodule

bind va_table_walker vtw_checker #(.VA_W(VA_W), .OFS_W(OFS_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_req (mem_req),
    .mem_ack (mem_ack),
    .mem_addr(mem_addr),
    .xl_done (xl_done),
    .xl_pa   (xl_pa),
    .xl_fault(xl_fault),
    .va_ofs  (va_q[OFS_W-1:0])
);

// File: tb/sim_va_table_walker.sv
`timescale 1ns/1ps
module sim_va_table_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_attr = '0, root_base = '0, xl_va = '0;
    logic        xl_req = 1'b0;
    logic        xl_done, xl_wp, mem_req;
    logic [31:0] xl_pa, mem_addr;
    logic [2:0]  xl_fault;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    va_table_walker u0 (
        .clk(clk), .rst_n(rst_n), .root_attr(root_attr), .root_base(root_base),
        .xl_req(xl_req), .xl_va(xl_va), .xl_done(xl_done), .xl_pa(xl_pa),
        .xl_wp(xl_wp), .xl_fault(xl_fault), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int errors = 0;
    int checks = 0;

    // memory image
    function automatic logic [31:0] mem_fn(logic [31:0] a);
        case (a)
            32'h1008: mem_fn = 32'h000A_0002; // A1: short next, flag0 limit 10
            32'h100C: mem_fn = 32'h0000_2005;
            32'h1010: mem_fn = 32'h0000_0005; // A2: long page, wp
            32'h1014: mem_fn = 32'h1234_5678;
            32'h1020: mem_fn = 32'h8005_0003; // A4: long next, flag1 limit 5
            32'h1024: mem_fn = 32'h0000_3000;
            32'h2000: mem_fn = 32'h0000_4002; // B0 table
            32'h2004: mem_fn = 32'hABCD_E001; // B1 page
            32'h200C: mem_fn = 32'h0000_4006; // B3 table, wp
            32'h3018: mem_fn = 32'h5555_6001; // B6 page
            32'h4000: mem_fn = 32'h8765_4321; // C0 page
            32'h4004: mem_fn = 32'h0000_A005; // C1 page, wp
            32'h400C: mem_fn = 32'h0000_5002; // C3 table type
            default:  mem_fn = 32'h0000_0000;
        endcase
    endfunction

    // memory responder
    int          rd_cnt = 0;
    int          ack_lat = 0;
    int          lat_cnt = 0;
    logic [31:0] addr_log [8];

    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            if (lat_cnt >= ack_lat) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_fn(mem_addr);
                if (rd_cnt < 8) addr_log[rd_cnt] = mem_addr;
                rd_cnt++;
                lat_cnt = 0;
            end else begin
                lat_cnt++;
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    function automatic logic [31:0] mkva(int a, int b, int c, int o);
        mkva = {a[6:0], b[5:0], c[5:0], o[12:0]};
    endfunction

    typedef struct packed {
        logic [31:0] ra;
        logic [31:0] va;
        logic [31:0] pa;
        logic        wp;
        logic [2:0]  flt;
        logic [3:0]  rds;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam logic [31:0] RB = 32'h0000_100F;
    localparam vec_t VECS [NV] = '{
        '{32'h007F0002, mkva(1,0,0,13'h0ABC), 32'h87654ABC, 1'b0, 3'd0, 4'd4, 4'd3}, // R3 full walk
        '{32'h007F0002, mkva(1,0,1,13'h1FFF), 32'h0000BFFF, 1'b1, 3'd0, 4'd4, 4'd9}, // R9 wp at C
        '{32'h007F0002, mkva(1,1,0,13'h0123), 32'hABCDE123, 1'b0, 3'd0, 4'd3, 4'd4}, // R4 page at B
        '{32'h007F0002, mkva(2,0,0,13'h1555), 32'h12345555, 1'b1, 3'd0, 4'd2, 4'd4}, // R4 page at A
        '{32'h007F0002, mkva(3,0,0,0),        32'h0,        1'b0, 3'd2, 4'd1, 4'd5}, // R5 A invalid
        '{32'h007F0002, mkva(1,2,0,0),        32'h0,        1'b0, 3'd3, 4'd3, 4'd5}, // R5 B invalid
        '{32'h007F0002, mkva(1,0,2,0),        32'h0,        1'b0, 3'd4, 4'd4, 4'd5}, // R5 C invalid
        '{32'h007F0002, mkva(1,0,3,0),        32'h0,        1'b0, 3'd7, 4'd4, 4'd8}, // R8
        '{32'h007F0002, mkva(1,3,0,13'h0010), 32'h87654010, 1'b1, 3'd0, 4'd4, 4'd9}, // R9 wp at B
        '{32'h007F0002, mkva(1,11,0,0),       32'h0,        1'b0, 3'd6, 4'd1, 4'd7}, // R7 above limit
        '{32'h007F0002, mkva(1,10,0,0),       32'h0,        1'b0, 3'd3, 4'd3, 4'd7}, // R7 at limit
        '{32'h007F0002, mkva(4,4,0,0),        32'h0,        1'b0, 3'd6, 4'd1, 4'd7}, // R7 below lower
        '{32'h007F0002, mkva(4,6,0,13'h0777), 32'h55556777, 1'b0, 3'd0, 4'd3, 4'd7}, // R7 lower ok
        '{32'h007F0002, mkva(4,5,0,0),        32'h0,        1'b0, 3'd3, 4'd3, 4'd7}, // R7 lower edge
        '{32'h00030002, mkva(4,0,0,0),        32'h0,        1'b0, 3'd5, 4'd0, 4'd6}, // R6 above
        '{32'h00030002, mkva(3,0,0,0),        32'h0,        1'b0, 3'd2, 4'd1, 4'd6}, // R6 edge
        '{32'h00000000, mkva(1,0,0,0),        32'h0,        1'b0, 3'd1, 4'd0, 4'd5}, // R5 root
        '{32'h00000005, mkva(1,0,0,13'h0ABC), 32'h00000ABC, 1'b1, 3'd0, 4'd0, 4'd4}, // R4 root page
        '{32'h007F0006, mkva(1,0,0,13'h0ABC), 32'h87654ABC, 1'b1, 3'd0, 4'd4, 4'd9}, // R9 root wp
        '{32'h80020002, mkva(1,0,0,0),        32'h0,        1'b0, 3'd5, 4'd0, 4'd6}, // R6 lower
        '{32'h80020002, mkva(2,0,0,13'h0001), 32'h12344001, 1'b1, 3'd0, 4'd2, 4'd6}  // R6 lower ok
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    task automatic start_walk(input logic [31:0] ra, input logic [31:0] va, input int lat);
        @(negedge clk);
        root_attr = ra; root_base = RB; xl_va = va; xl_req = 1'b1;
        rd_cnt = 0; ack_lat = lat; lat_cnt = 0;
        @(negedge clk);
        xl_req = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!xl_done && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(xl_done == 0 && mem_req == 0, "R1 done/req", {30'd0, xl_done, mem_req}, 0);
        chk(xl_pa == 0 && xl_wp == 0 && xl_fault == 0, "R1 result", xl_pa | {28'd0, xl_wp, xl_fault}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // vector table
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            start_walk(VECS[i].ra, VECS[i].va, 0);
            wait_done();
            chk(xl_done, {tag, " done"}, {31'd0, xl_done}, 1);
            chk(xl_pa == VECS[i].pa, {tag, " pa"}, xl_pa, VECS[i].pa);
            chk(xl_wp == VECS[i].wp, {tag, " wp"}, {31'd0, xl_wp}, {31'd0, VECS[i].wp});
            chk(xl_fault == VECS[i].flt, {tag, " fault"}, {29'd0, xl_fault}, {29'd0, VECS[i].flt});
            chk(rd_cnt == int'(VECS[i].rds), {tag, " reads"}, rd_cnt, {28'd0, VECS[i].rds});
        end

        // R3 address sequence with slow acknowledge (R11 hold)
        start_walk(32'h007F0002, mkva(1,0,0,13'h0ABC), 3);
        wait_done();
        chk(addr_log[0] == 32'h1008, "R3 A attr addr", addr_log[0], 32'h1008);
        chk(addr_log[1] == 32'h100C, "R3 A addr word", addr_log[1], 32'h100C);
        chk(addr_log[2] == 32'h2000, "R3 B addr", addr_log[2], 32'h2000);
        chk(addr_log[3] == 32'h4000, "R3 C addr", addr_log[3], 32'h4000);
        chk(xl_pa == 32'h87654ABC, "R11 slow ack pa", xl_pa, 32'h87654ABC);

        // R10 one-cycle done and held result
        @(negedge clk);
        chk(!xl_done, "R10 done low after pulse", {31'd0, xl_done}, 0);
        repeat (5) @(negedge clk);
        chk(xl_pa == 32'h87654ABC && xl_fault == 0, "R10 held pa", xl_pa, 32'h87654ABC);

        // R12 request during a walk is ignored
        start_walk(32'h007F0002, mkva(1,0,0,13'h0ABC), 2);
        repeat (2) @(negedge clk);
        xl_va = mkva(2,0,0,13'h1555); xl_req = 1'b1;
        @(negedge clk);
        xl_req = 1'b0;
        wait_done();
        chk(xl_pa == 32'h87654ABC, "R12 busy request ignored", xl_pa, 32'h87654ABC);
        chk(rd_cnt == 4, "R12 reads", rd_cnt, 4);
        repeat (3) @(negedge clk);
        chk(!xl_done && !mem_req, "R12 no second walk", {30'd0, xl_done, mem_req}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule